// File: doc/BRIEF.md
# Capture/Compare Channel Array

This block is a bank of sixteen capture/compare channels driven by two shared 16-bit time bases. Each time base counts either prescaled clock-enable pulses or rising edges on its own external count input. When it steps past all-ones it reloads from its own reload register. Each channel is tied to one of the two time bases. It either records the time base value when its input pin shows the chosen edge, or watches the time base and acts on its output pin and its interrupt pulse when the two values become equal.

Software programs the block through a single write port. Addresses `0..NCH-1` hold channel values. Addresses `NCH..2*NCH-1` hold channel configuration words. Address `2*NCH + k` selects the timer registers: k=0/1 is the timer 0/1 count value, k=2/3 is the timer 0/1 reload value, and k=4/5 is the timer 0/1 control word. Channel values can only be observed through compare events, and time base values only through captures and matches.

Top module: `ccu_array`

## Requirements
- R1: After reset every pin output and interrupt pulse is 0, every channel is disabled (mode code 0), and both timers are stopped, with count, reload and channel values at 0; a disabled channel never pulses or moves its pin.
- R2: Control word bits [3:0] give a prescale exponent k, bit 4 is run and bit 5 selects the external source. With run=1 and bit 5 = 0, the timer advances by one every 2^k cycles in which `tickEn` is high. Any control write clears the prescale count. While `tickEn` is low, the timer does not advance.
- R3: An advance from 0xFFFF loads the timer's reload value rather than zero. A write to the count address loads the count directly and is not an advance.
- R4: With control bit 5 set, the timer advances once for each rising edge of its `extCount` bit, seen through a two-stage synchronizer. `tickEn` and k are then ignored.
- R5: Configuration bits [2:0] = 1, 2 or 3 capture on a rising, falling or either edge of the channel pin. A capture latches the assigned timer value into the channel value and gives a one-cycle interrupt pulse on the third clock edge after the pin change. In single-edge modes the opposite edge has no effect.
- R6: Mode code 4 pulses the interrupt on every compare match, several per timer period if the value is rewritten.
- R7: Mode code 5 toggles the pin and pulses the interrupt on every compare match.
- R8: Mode code 6 pulses the interrupt only for the first match in a timer period. The channel is re-armed by an overflow of its timer or by a write to its configuration.
- R9: Mode code 7 drives the pin to 1 and pulses the interrupt on the first match of a period, and drives the pin to 0 when its timer overflows. A match in the overflow cycle itself sets the pin.
- R10: Configuration bit 4 on a channel i below NCH/2 in mode 5 makes a match of channel i+NCH/2 (in any compare mode) also toggle pin i. Simultaneous matches give a single toggle. Each channel's interrupt still follows only its own match, and the partner's pin is untouched in mode 4.
- R11: A match counts only in the cycle after the assigned timer advanced to the equal value; equality created by writing a value or count, or by a stopped timer, gives no event. Compare actions appear on the clock edge after the advance.
- R12: Configuration bit 3 assigns a channel to timer 1 (0 selects timer 0), for capture and compare alike; the other timer's activity has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Clock enable feeding both prescalers |
| extCount | input | 2 | External count inputs, bit t for timer t |
| ccPinIn | input | NCH | Channel input pins (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | clog2(NCH)+2 | Register write address |
| wrData | input | TW | Register write data |
| ccPinOut | output | NCH | Channel pin drive values |
| ccIrq | output | NCH | Per-channel one-cycle interrupt pulses |

## Verification
The bench rewrites a compare value within a period. A design that treats mode 6 like mode 4 gives a second pulse, and one that treats mode 7 like mode 4 re-sets the pin early. It lets a timer wrap past 0xFFFF with a nonzero reload. A design that wraps to zero misses the next match, and one that forgets the overflow leaves the set/clear pin high.

Further tests show that a stationary equal value fires in a design that compares continuously. A paired channel pair with matches at two times toggles its shared pin twice, while an unpaired pair toggles once. Captures are replayed as compare matches, so a wrong timer or an opposite edge shows up as a missing or extra pulse.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [2:0] {
    MODE_OFF        = 3'd0,
    MODE_CAP_RISE   = 3'd1,
    MODE_CAP_FALL   = 3'd2,
    MODE_CAP_BOTH   = 3'd3,
    MODE_CMP_EVERY  = 3'd4,
    MODE_CMP_TOGGLE = 3'd5,
    MODE_CMP_ONCE   = 3'd6,
    MODE_CMP_SETCLR = 3'd7
  } ccMode_e;

  typedef struct packed {
    ccMode_e mode;
    logic    timSel;
  } chCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       valWr;
    logic [1:0] timWr;
    logic [1:0] rldWr;
    logic [1:0] ctlWr;
  } ccStb_t;

  localparam logic [1:0] REG_VAL = 2'd0;
  localparam logic [1:0] REG_CFG = 2'd1;
  localparam logic [1:0] REG_TIM = 2'd2;

endpackage

// File: rtl/ccu_sync.sv
module ccu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] lvlNow,
  output logic [W-1:0] lvlPrev
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      lvlNow  <= '0;
      lvlPrev <= '0;
    end else begin
      stage1  <= asyncIn;
      lvlNow  <= stage1;
      lvlPrev <= lvlNow;
    end
  end
endmodule

// File: rtl/ccu_timebase.sv
module ccu_timebase #(
  parameter int TW  = 16,
  parameter int PSW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          extRise,
  input  logic          wrTim,
  input  logic          wrRld,
  input  logic          wrCtl,
  input  logic [TW-1:0] wrData,
  output logic [TW-1:0] timVal,
  output logic          stepped,
  output logic          ovf
);
  localparam int PCW = (1 << PSW) - 1;

  logic [TW-1:0]  rldReg;
  logic [PSW-1:0] shiftQ;
  logic           runQ;
  logic           extQ;
  logic [PCW-1:0] preCnt;
  logic [PCW-1:0] preMask;
  logic           tick;

  assign preMask = (PCW'(1) << shiftQ) - PCW'(1);
  assign tick    = runQ && (extQ ? extRise : (tickEn && (preCnt == preMask)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rldReg  <= '0;
      shiftQ  <= '0;
      runQ    <= 1'b0;
      extQ    <= 1'b0;
      preCnt  <= '0;
      timVal  <= '0;
      stepped <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      stepped <= 1'b0;
      ovf     <= 1'b0;
      if (wrCtl) begin
        shiftQ <= wrData[PSW-1:0];
        runQ   <= wrData[PSW];
        extQ   <= wrData[PSW+1];
        preCnt <= '0;
      end else if (runQ && !extQ && tickEn) begin
        preCnt <= (preCnt == preMask) ? '0 : preCnt + PCW'(1);
      end
      if (wrRld) rldReg <= wrData;
      if (wrTim) begin
        timVal <= wrData;
      end else if (tick) begin
        stepped <= 1'b1;
        if (&timVal) begin
          timVal <= rldReg;
          ovf    <= 1'b1;
        end else begin
          timVal <= timVal + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ccu_datapath.sv
module ccu_datapath
  import ccu_pkg::*;
#(
  parameter int NCH = 16,
  parameter int TW  = 16,
  parameter int PSW = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickEn,
  input  logic [1:0]              extRise,
  input  ccStb_t                  stb,
  input  logic [CHW-1:0]          wrIdx,
  input  logic [TW-1:0]           wrData,
  input  logic [NCH-1:0]          capStb,
  input  logic [NCH-1:0]          capSel,
  output logic [1:0][TW-1:0]      timVal,
  output logic [1:0]              stepped,
  output logic [1:0]              ovf,
  output logic [1:0][NCH-1:0]     eqVec
);

  for (genvar t = 0; t < 2; t++) begin : gTim
    ccu_timebase #(.TW(TW), .PSW(PSW)) uTb (
      .clk     (clk),
      .rstN    (rstN),
      .tickEn  (tickEn),
      .extRise (extRise[t]),
      .wrTim   (stb.timWr[t]),
      .wrRld   (stb.rldWr[t]),
      .wrCtl   (stb.ctlWr[t]),
      .wrData  (wrData),
      .timVal  (timVal[t]),
      .stepped (stepped[t]),
      .ovf     (ovf[t])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : gVal
    logic [TW-1:0] valQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valQ <= '0;
      end else if (capStb[i]) begin
        valQ <= timVal[capSel[i]];
      end else if (stb.valWr && (wrIdx == CHW'(i))) begin
        valQ <= wrData;
      end
    end

    assign eqVec[0][i] = (valQ == timVal[0]);
    assign eqVec[1][i] = (valQ == timVal[1]);
  end
endmodule

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW  = $clog2(NCH),
  localparam int AW   = CHW + 2,
  localparam int HALF = NCH / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [4:0]          cfgData,
  input  logic [NCH-1:0]      pinRise,
  input  logic [NCH-1:0]      pinFall,
  input  logic [1:0]          stepped,
  input  logic [1:0]          ovf,
  input  logic [1:0][NCH-1:0] eqVec,
  output ccStb_t              stb,
  output logic [CHW-1:0]      wrIdx,
  output logic [NCH-1:0]      capStb,
  output logic [NCH-1:0]      capSel,
  output logic [NCH-1:0]      pinOut,
  output logic [NCH-1:0]      irqOut
);
  logic [1:0]      region;
  logic            cfgWr;
  logic [NCH-1:0]  hitVec;
  logic [HALF-1:0] pairReg;

  assign region = wrAddr[AW-1:AW-2];
  assign wrIdx  = wrAddr[CHW-1:0];
  assign cfgWr  = wrEn && (region == REG_CFG);

  always_comb begin
    stb.valWr = wrEn && (region == REG_VAL);
    for (int t = 0; t < 2; t++) begin
      stb.timWr[t] = wrEn && (region == REG_TIM) && (wrIdx == CHW'(t));
      stb.rldWr[t] = wrEn && (region == REG_TIM) && (wrIdx == CHW'(t + 2));
      stb.ctlWr[t] = wrEn && (region == REG_TIM) && (wrIdx == CHW'(t + 4));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairReg <= '0;
    end else begin
      for (int k = 0; k < HALF; k++) begin
        if (cfgWr && (wrIdx == CHW'(k))) pairReg[k] <= cfgData[4];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : gCh
    chCfg_t cfgQ;
    logic   pinQ;
    logic   irqQ;
    logic   armQ;
    logic   tsel;
    logic   hit;
    logic   myOvf;
    logic   capEdge;
    logic   cfgHit;
    logic   partnerHit;

    assign tsel   = cfgQ.timSel;
    assign hit    = cfgQ.mode[2] && stepped[tsel] && eqVec[tsel][i];
    assign myOvf  = ovf[tsel];
    assign cfgHit = cfgWr && (wrIdx == CHW'(i));
    assign hitVec[i] = hit;

    if (i < HALF) begin : gPair
      assign partnerHit = pairReg[i] && hitVec[i + HALF];
    end else begin : gNoPair
      assign partnerHit = 1'b0;
    end

    always_comb begin
      unique case (cfgQ.mode)
        MODE_CAP_RISE: capEdge = pinRise[i];
        MODE_CAP_FALL: capEdge = pinFall[i];
        MODE_CAP_BOTH: capEdge = pinRise[i] | pinFall[i];
        default:       capEdge = 1'b0;
      endcase
    end

    assign capStb[i] = capEdge && !cfgHit;
    assign capSel[i] = tsel;
    assign pinOut[i] = pinQ;
    assign irqOut[i] = irqQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ <= '{mode: MODE_OFF, timSel: 1'b0};
        pinQ <= 1'b0;
        irqQ <= 1'b0;
        armQ <= 1'b0;
      end else begin
        irqQ <= 1'b0;
        if (cfgHit) begin
          cfgQ.mode   <= ccMode_e'(cfgData[2:0]);
          cfgQ.timSel <= cfgData[3];
          armQ        <= 1'b1;
        end else begin
          unique case (cfgQ.mode)
            MODE_CAP_RISE, MODE_CAP_FALL, MODE_CAP_BOTH: begin
              if (capEdge) irqQ <= 1'b1;
            end
            MODE_CMP_EVERY: begin
              if (hit) irqQ <= 1'b1;
            end
            MODE_CMP_TOGGLE: begin
              if (hit || partnerHit) pinQ <= ~pinQ;
              if (hit) irqQ <= 1'b1;
            end
            MODE_CMP_ONCE: begin
              if (hit && (armQ || myOvf)) begin
                irqQ <= 1'b1;
                armQ <= 1'b0;
              end else if (myOvf) begin
                armQ <= 1'b1;
              end
            end
            MODE_CMP_SETCLR: begin
              if (hit && (armQ || myOvf)) begin
                pinQ <= 1'b1;
                irqQ <= 1'b1;
                armQ <= 1'b0;
              end else if (myOvf) begin
                pinQ <= 1'b0;
                armQ <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ccu_array.sv
module ccu_array
  import ccu_pkg::*;
#(
  parameter int NCH = 16,
  parameter int TW  = 16,
  parameter int PSW = 4,
  localparam int CHW = $clog2(NCH),
  localparam int AW  = CHW + 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tickEn,
  input  logic [1:0]     extCount,
  input  logic [NCH-1:0] ccPinIn,
  input  logic           wrEn,
  input  logic [AW-1:0]  wrAddr,
  input  logic [TW-1:0]  wrData,
  output logic [NCH-1:0] ccPinOut,
  output logic [NCH-1:0] ccIrq
);
  logic [NCH-1:0]      pinLvl;
  logic [NCH-1:0]      pinPrev;
  logic [1:0]          extLvl;
  logic [1:0]          extPrev;
  logic [NCH-1:0]      pinRise;
  logic [NCH-1:0]      pinFall;
  logic [1:0]          extRise;
  ccStb_t              stb;
  logic [CHW-1:0]      wrIdx;
  logic [NCH-1:0]      capStb;
  logic [NCH-1:0]      capSel;
  logic [1:0][TW-1:0]  timVal;
  logic [1:0]          stepVec;
  logic [1:0]          ovfVec;
  logic [1:0][NCH-1:0] eqVec;

  ccu_sync #(.W(NCH)) uPinSync (
    .clk(clk), .rstN(rstN), .asyncIn(ccPinIn), .lvlNow(pinLvl), .lvlPrev(pinPrev)
  );

  ccu_sync #(.W(2)) uExtSync (
    .clk(clk), .rstN(rstN), .asyncIn(extCount), .lvlNow(extLvl), .lvlPrev(extPrev)
  );

  assign pinRise = pinLvl & ~pinPrev;
  assign pinFall = ~pinLvl & pinPrev;
  assign extRise = extLvl & ~extPrev;

  ccu_ctrl #(.NCH(NCH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .cfgData (wrData[4:0]),
    .pinRise (pinRise),
    .pinFall (pinFall),
    .stepped (stepVec),
    .ovf     (ovfVec),
    .eqVec   (eqVec),
    .stb     (stb),
    .wrIdx   (wrIdx),
    .capStb  (capStb),
    .capSel  (capSel),
    .pinOut  (ccPinOut),
    .irqOut  (ccIrq)
  );

  ccu_datapath #(.NCH(NCH), .TW(TW), .PSW(PSW)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .extRise (extRise),
    .stb     (stb),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .capStb  (capStb),
    .capSel  (capSel),
    .timVal  (timVal),
    .stepped (stepVec),
    .ovf     (ovfVec),
    .eqVec   (eqVec)
  );
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk #(
  parameter int NCH = 16,
  parameter int TW  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NCH-1:0]      ccPinOut,
  input logic [NCH-1:0]      ccIrq,
  input logic [1:0]          stepped,
  input logic [1:0]          ovf,
  input logic [NCH-1:0]      capStb,
  input logic [1:0][TW-1:0]  timVal
);

  // R7 R9 R10 R11
  pin_needs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ccPinOut != $past(ccPinOut)) |-> $past(|stepped));

  // R5 R6 R11
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ccIrq) |-> $past((|stepped) || (|capStb)));

  for (genvar t = 0; t < 2; t++) begin : gT
    // R3
    wrap_from_top_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovf[t] |-> (stepped[t] && ($past(timVal[t]) == {TW{1'b1}})));

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stepped[t] && !ovf[t]) |-> (timVal[t] == TW'($past(timVal[t]) + TW'(1))));
  end
endmodule

bind ccu_array ccu_array_chk #(.NCH(NCH), .TW(TW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ccPinOut (ccPinOut),
  .ccIrq    (ccIrq),
  .stepped  (stepVec),
  .ovf      (ovfVec),
  .capStb   (capStb),
  .timVal   (timVal)
);

// File: tb/tb_ccu_array.sv
module tb_ccu_array;
  localparam int  NCH = 16;
  localparam int  TW  = 16;
  localparam int  AW  = 6;
  localparam time CLK_PERIOD = 10;
  localparam int  A_CFG = 16, A_TIM = 32, A_RLD = 34, A_CTL = 36;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           tickEn = 1'b1;
  logic [1:0]     extCount = '0;
  logic [NCH-1:0] pinIn = '0;
  logic           wrEn = 1'b0;
  logic [AW-1:0]  wrAddr = '0;
  logic [TW-1:0]  wrData = '0;
  logic [NCH-1:0] pinOut;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  int irqCnt [NCH];
  int togCnt [NCH];
  logic [NCH-1:0] lastPin = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccu_array dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extCount(extCount), .ccPinIn(pinIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ccPinOut(pinOut), .ccIrq(irq)
  );

  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < NCH; i++) begin
        if (irq[i]) irqCnt[i] <= irqCnt[i] + 1;
        if (pinOut[i] !== lastPin[i]) togCnt[i] <= togCnt[i] + 1;
      end
      lastPin <= pinOut;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = TW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // run timer t for exactly n advancing edges (prescale shift s), then settle
  task automatic runT(input int t, input int n, input int s);
    wr(A_CTL + t, 16 | s);
    repeat (n - 1) @(negedge clk);
    wr(A_CTL + t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    int sum;
    chk("R1 pins after reset", int'(pinOut), 0);
    chk("R1 irq after reset", int'(irq), 0);
    runT(0, 20, 0);
    runT(1, 20, 0);
    sum = 0;
    for (int i = 0; i < NCH; i++) sum += irqCnt[i] + togCnt[i];
    chk("R1 disabled channels silent", sum, 0);
  endtask

  task automatic tEvery();
    wr(A_TIM, 0); wr(A_RLD, 0);
    wr(A_CFG + 0, 4); wr(0, 5);
    runT(0, 10, 0);
    chk("R6 one match in ten steps", irqCnt[0], 1);
    chk("R6 pin untouched", togCnt[0], 0);
  endtask

  task automatic tPrescale();
    wr(A_TIM, 7); wr(A_CFG + 1, 4); wr(1, 7);
    repeat (10) @(negedge clk);
    chk("R11 stationary equality", irqCnt[1], 0);
    wr(1, 9);
    runT(0, 7, 2);
    chk("R2 prescale 4 gives one step in 7", irqCnt[1], 0);
    wr(A_TIM, 7);
    runT(0, 8, 2);
    chk("R2 prescale 4 gives two steps in 8", irqCnt[1], 1);
    tickEn = 1'b0;
    wr(A_TIM, 8);
    runT(0, 20, 0);
    chk("R2 tickEn low holds timer", irqCnt[1], 1);
    tickEn = 1'b1;
  endtask

  task automatic tSetClr();
    wr(A_TIM + 1, 'hFFF0); wr(A_RLD + 1, 'hFFF0);
    wr(A_CFG + 2, 7 | 8); wr(2, 'hFFF4);
    runT(1, 10, 0);
    chk("R9 pin set on match", int'(pinOut[2]), 1);
    chk("R9 irq on match", irqCnt[2], 1);
    wr(2, 'hFFFC);
    runT(1, 3, 0);
    chk("R9 second match same period ignored", irqCnt[2], 1);
    runT(1, 3, 0);
    chk("R9 pin cleared on overflow", int'(pinOut[2]), 0);
    runT(1, 13, 0);
    chk("R3 reload value used after wrap", irqCnt[2], 2);
    chk("R9 pin set again next period", int'(pinOut[2]), 1);
  endtask

  task automatic tOnce();
    wr(A_TIM, 0); wr(A_RLD, 0);
    wr(A_CFG + 3, 6); wr(A_CFG + 4, 4);
    wr(3, 3); wr(4, 3);
    runT(0, 5, 0);
    chk("R8 first match fires", irqCnt[3], 1);
    wr(3, 8); wr(4, 8);
    runT(0, 5, 0);
    chk("R8 later match same period blocked", irqCnt[3], 1);
    chk("R6 every-match fires again", irqCnt[4], 2);
    wr(A_TIM, 'hFFFD);
    runT(0, 3, 0);
    runT(0, 8, 0);
    chk("R8 re-armed by overflow", irqCnt[3], 2);
  endtask

  task automatic tToggle();
    wr(A_TIM + 1, 0); wr(A_RLD + 1, 0);
    wr(A_CFG + 5, 5 | 8); wr(5, 2);
    runT(1, 5, 0);
    chk("R7 pin toggled high", int'(pinOut[5]), 1);
    wr(A_TIM + 1, 0);
    runT(1, 5, 0);
    chk("R7 pin toggled low", int'(pinOut[5]), 0);
    chk("R7 irq per match", irqCnt[5], 2);
  endtask

  task automatic tPair();
    wr(A_TIM, 0); wr(A_RLD, 0);
    wr(A_CFG + 6, 5 | 16); wr(6, 3);
    wr(A_CFG + 14, 4); wr(14, 6);
    wr(A_CFG + 7, 5); wr(7, 3);
    wr(A_CFG + 15, 4); wr(15, 6);
    runT(0, 8, 0);
    chk("R10 paired pin toggled twice", togCnt[6], 2);
    chk("R10 unpaired pin toggled once", togCnt[7], 1);
    chk("R10 own irq only", irqCnt[6], 1);
    chk("R10 partner irq", irqCnt[14], 1);
    chk("R10 partner pin untouched", togCnt[14], 0);
  endtask

  task automatic tSelect();
    wr(A_TIM, 0); wr(A_TIM + 1, 0);
    wr(A_CFG + 8, 4 | 8); wr(8, 4);
    runT(0, 8, 0);
    chk("R12 other timer ignored", irqCnt[8], 0);
    runT(1, 8, 0);
    chk("R12 assigned timer matches", irqCnt[8], 1);
  endtask

  task automatic tExt();
    wr(A_TIM + 1, 0);
    wr(A_CFG + 9, 4 | 8); wr(9, 5);
    tickEn = 1'b0;
    wr(A_CTL + 1, 16 | 32);
    for (int p = 0; p < 4; p++) begin
      extCount[1] = 1'b1; repeat (3) @(negedge clk);
      extCount[1] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R4 four edges no match", irqCnt[9], 0);
    extCount[1] = 1'b1; repeat (3) @(negedge clk);
    extCount[1] = 1'b0; repeat (6) @(negedge clk);
    chk("R4 fifth edge matches", irqCnt[9], 1);
    wr(A_CTL + 1, 0);
    tickEn = 1'b1;
  endtask

  task automatic tCapture();
    wr(A_TIM, 'h1234);
    wr(A_CFG + 10, 1);
    pinIn[10] = 1'b1; repeat (6) @(negedge clk);
    chk("R5 rising capture irq", irqCnt[10], 1);
    pinIn[10] = 1'b0; repeat (6) @(negedge clk);
    chk("R5 falling ignored in rise mode", irqCnt[10], 1);
    wr(A_CFG + 10, 4);
    wr(A_TIM, 'h1233);
    runT(0, 1, 0);
    chk("R5 captured value equals timer", irqCnt[10], 2);
    wr(A_CFG + 10, 2);
    pinIn[10] = 1'b1; repeat (6) @(negedge clk);
    chk("R5 rising ignored in fall mode", irqCnt[10], 2);
    pinIn[10] = 1'b0; repeat (6) @(negedge clk);
    chk("R5 falling capture irq", irqCnt[10], 3);
    wr(A_CFG + 10, 3);
    pinIn[10] = 1'b1; repeat (6) @(negedge clk);
    pinIn[10] = 1'b0; repeat (6) @(negedge clk);
    chk("R5 both edges capture", irqCnt[10], 5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEvery();
    tPrescale();
    tSetClr();
    tOnce();
    tToggle();
    tPair();
    tSelect();
    tExt();
    tCapture();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule